// File: doc/BRIEF.md
# Priority-Multiplexed General-Purpose I/O Port

This block controls a group of general-purpose pads (eight by default) and decides, pin by pin, what drives each pad and whether the output driver is on. Software uses a small register bus to set an output-value register and a direction register. Peripherals can take over a pin. A timer can drive any pin through its output-compare path. A CAN controller owns two fixed pins, one for transmit and one for receive, and it wins over both the timer and the register-driven value. A third, read-only register always shows the synchronized pad levels. Software can compare it with the value it drives to find a shorted or overloaded output.

Every pad input passes through a two-flop synchronizer. The synchronized value feeds all read paths, the CAN receive line and the timer capture inputs. A configuration warning bit is raised for each pin where timer input capture is enabled while the direction register makes that pin an output, because a capture cannot work on such a pin.

Top module: `mgp_port`

## Requirements
- R1: After reset the output-value and direction registers read 0, so every pad has its output enable low unless a peripheral claims the pin.
- R2: On a pin that no peripheral owns, pad_oe follows the direction bit (1 = output) and pad_out follows the output-value bit. A write with bus_sel and bus_wr high to address 0 loads the output-value register, and a write to address 1 loads the direction register, on the next clock edge.
- R3: A read of address 0 returns the register bit for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0. A read of address 1 returns the direction register.
- R4: While can_en is 1, pin 1 is the CAN transmit pin. Its output enable is 1 and it drives can_tx_data, whatever the timer or register settings for that pin.
- R5: While can_en is 1, pin 0 is the CAN receive pin. Its output enable is 0, pad_out is 0 on that pin, and can_rx_data equals the synchronized level of pad 0. While can_en is 0, can_rx_data is 1.
- R6: On a pin that CAN does not own, tmr_oc_en high sets the output enable to 1 and drives tmr_oc_val, whatever the register settings for that pin.
- R7: A read of address 2 returns the synchronized level of every pad, whatever the direction or ownership of the pin. A pad change shows up on that read two clock edges later and not after one.
- R8: Writes to address 2 have no effect. The output-value and direction registers and every read keep their values.
- R9: Reset does not touch the synchronizer. While rst_n is low, a read of address 2 still follows the pads, with the two-edge delay.
- R10: cfg_warn[i] is 1 exactly when tmr_ic_en[i] is 1 and direction bit i is 1.
- R11: tmr_cap_in carries the synchronized pad levels, with the same two-edge delay as the address 2 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 output value, 1 direction, 2 pad levels |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Value driven toward each pad |
| pad_oe | output | 8 | Output enable per pad |
| tmr_oc_en | input | 8 | Timer output-compare ownership per pin |
| tmr_oc_val | input | 8 | Timer output-compare value per pin |
| tmr_ic_en | input | 8 | Timer input capture enabled per pin |
| tmr_cap_in | output | 8 | Synchronized pad levels for the timer capture logic |
| can_en | input | 1 | CAN controller owns its transmit and receive pins |
| can_tx_data | input | 1 | CAN transmit bit |
| can_rx_data | output | 1 | CAN receive bit |
| cfg_warn | output | 8 | Capture enabled on a pin configured as output |

## Verification
Ownership, pad_out, pad_oe and cfg_warn are combinational from the registers and the peripheral inputs. A register write is visible one edge after the write strobe. Pad levels reach the reads, can_rx_data and tmr_cap_in after exactly two edges. The bench drives inputs on the falling edge. After a pad change it waits at least two rising edges before it samples a pad-derived result. To pin down the latency, it also samples once after a single edge, where the old value must still be present. All results are sampled 1 ns after a falling edge, so no sample is taken at an active edge.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_OUTVAL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PADS   = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO   = 2'd0,
    OWN_TIMER  = 2'd1,
    OWN_CAN_TX = 2'd2,
    OWN_CAN_RX = 2'd3
  } pin_owner_e;
endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // Deliberately reset-free: pad levels are observable during reset.
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;
  logic [WIDTH-1:0] meta_d;
  logic [WIDTH-1:0] stab_d;

  always_comb begin
    meta_d = d_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk) begin
    meta_q <= meta_d;
    stab_q <= stab_d;
  end

  assign q_o = stab_q;
endmodule

// File: rtl/mgp_regs.sv
module mgp_regs
  import mgp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pads_sync,
  output logic [WIDTH-1:0]  outval_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  logic             wr_any;
  logic             outval_en;
  logic             dir_en;
  logic [WIDTH-1:0] outval_d;
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    wr_any    = bus_sel & bus_wr;
    outval_en = wr_any & (bus_addr == ADDR_OUTVAL);
    dir_en    = wr_any & (bus_addr == ADDR_DIR);
    outval_d  = bus_wdata;
    dir_d     = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outval_q <= '0;
      dir_q    <= '0;
    end else begin
      if (outval_en) outval_q <= outval_d;
      if (dir_en)    dir_q    <= dir_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_OUTVAL: bus_rdata = (outval_q & dir_q) | (pads_sync & ~dir_q);
      ADDR_DIR:    bus_rdata = dir_q;
      ADDR_PADS:   bus_rdata = pads_sync;
      default:     bus_rdata = '0;
    endcase
  end

  // R2: a write to the output-value address lands on the next edge
  p_outval_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_OUTVAL) |=> (outval_q == $past(bus_wdata)));

  // R8: the pad-level address is read-only
  p_pads_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_PADS) |=> ($stable(outval_q) && $stable(dir_q)));
endmodule

// File: rtl/mgp_pin_mux.sv
module mgp_pin_mux
  import mgp_pkg::*;
#(
  parameter bit IS_CAN_TX = 1'b0,
  parameter bit IS_CAN_RX = 1'b0
) (
  input  logic can_en,
  input  logic can_tx_data,
  input  logic oc_en,
  input  logic oc_val,
  input  logic dir_bit,
  input  logic outval_bit,
  output logic pad_out,
  output logic pad_oe
);
  pin_owner_e owner;

  // Fixed precedence: CAN, then timer output compare, then register.
  always_comb begin
    if (can_en && IS_CAN_TX)      owner = OWN_CAN_TX;
    else if (can_en && IS_CAN_RX) owner = OWN_CAN_RX;
    else if (oc_en)               owner = OWN_TIMER;
    else                          owner = OWN_GPIO;
  end

  always_comb begin
    unique case (owner)
      OWN_CAN_TX: begin pad_out = can_tx_data; pad_oe = 1'b1;    end
      OWN_CAN_RX: begin pad_out = 1'b0;        pad_oe = 1'b0;    end
      OWN_TIMER:  begin pad_out = oc_val;      pad_oe = 1'b1;    end
      default:    begin pad_out = outval_bit;  pad_oe = dir_bit; end
    endcase
  end
endmodule

// File: rtl/mgp_port.sv
module mgp_port
  import mgp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int CAN_TX_PIN = 1,
  parameter int CAN_RX_PIN = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  tmr_oc_en,
  input  logic [WIDTH-1:0]  tmr_oc_val,
  input  logic [WIDTH-1:0]  tmr_ic_en,
  output logic [WIDTH-1:0]  tmr_cap_in,
  input  logic              can_en,
  input  logic              can_tx_data,
  output logic              can_rx_data,
  output logic [WIDTH-1:0]  cfg_warn
);
  logic [WIDTH-1:0] pads_sync;
  logic [WIDTH-1:0] outval_q;
  logic [WIDTH-1:0] dir_q;

  mgp_sync #(.WIDTH(WIDTH)) u_sync (
    .clk (clk),
    .d_i (pad_in),
    .q_o (pads_sync)
  );

  mgp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pads_sync (pads_sync),
    .outval_q  (outval_q),
    .dir_q     (dir_q),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit IS_TX = (i == CAN_TX_PIN);
    localparam bit IS_RX = (i == CAN_RX_PIN);

    mgp_pin_mux #(.IS_CAN_TX(IS_TX), .IS_CAN_RX(IS_RX)) u_mux (
      .can_en      (can_en),
      .can_tx_data (can_tx_data),
      .oc_en       (tmr_oc_en[i]),
      .oc_val      (tmr_oc_val[i]),
      .dir_bit     (dir_q[i]),
      .outval_bit  (outval_q[i]),
      .pad_out     (pad_out[i]),
      .pad_oe      (pad_oe[i])
    );

    // R6: timer output compare beats the register on pins CAN does not hold
    p_timer_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_oc_en[i] && !(can_en && (IS_TX || IS_RX)))
        |-> (pad_oe[i] && pad_out[i] == tmr_oc_val[i]));

    // R2: an unclaimed pin follows the two registers
    p_gpio_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_oc_en[i] && !(can_en && (IS_TX || IS_RX)))
        |-> (pad_oe[i] == dir_q[i] && pad_out[i] == outval_q[i]));
  end

  always_comb begin
    tmr_cap_in  = pads_sync;
    can_rx_data = can_en ? pads_sync[CAN_RX_PIN] : 1'b1;
    cfg_warn    = tmr_ic_en & dir_q;
  end

  // R4: the CAN transmit pin is driven by the controller
  p_can_tx_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> (pad_oe[CAN_TX_PIN] && pad_out[CAN_TX_PIN] == can_tx_data));

  // R5: the CAN receive pin never drives
  p_can_rx_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> (!pad_oe[CAN_RX_PIN] && !pad_out[CAN_RX_PIN]));

  // R7: pad levels arrive at the capture path two edges late
  p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cap_in == $past(pad_in, 2));
endmodule

// File: tb/mgp_port_tb_top.sv
module mgp_port_tb_top;
  import mgp_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pad_in, pad_out, pad_oe;
  logic [7:0] tmr_oc_en, tmr_oc_val, tmr_ic_en, tmr_cap_in, cfg_warn;
  logic       can_en, can_tx_data, can_rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  mgp_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val), .tmr_ic_en(tmr_ic_en),
    .tmr_cap_in(tmr_cap_in), .can_en(can_en), .can_tx_data(can_tx_data),
    .can_rx_data(can_rx_data), .cfg_warn(cfg_warn)
  );

  typedef struct packed {
    logic       can_en;
    logic       can_tx;
    logic [7:0] oc_en;
    logic [7:0] oc_val;
    logic [7:0] dir;
    logic [7:0] outval;
    logic [7:0] pad;
    logic [7:0] e_out;
    logic [7:0] e_oe;
    logic [7:0] e_rd0;
    logic [7:0] e_rd2;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'h3C, 8'hA5, 8'hFF, 8'hA5, 8'h3C},
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, 8'h5A, 8'hC3, 8'h5A, 8'h0F, 8'hCA, 8'hC3},
    '{1'b0, 1'b0, 8'hF0, 8'h90, 8'h00, 8'hFF, 8'h00, 8'h9F, 8'hF0, 8'h00, 8'h00},
    '{1'b1, 1'b0, 8'h03, 8'h03, 8'hFF, 8'hFF, 8'h55, 8'hFC, 8'hFE, 8'hFF, 8'h55},
    '{1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h02, 8'h01, 8'h01},
    '{1'b0, 1'b0, 8'h81, 8'h01, 8'h7E, 8'h00, 8'hFF, 8'h01, 8'hFF, 8'h81, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pad_in = 8'h00; tmr_oc_en = 8'h00; tmr_oc_val = 8'h00; tmr_ic_en = 8'h00;
    can_en = 1'b0; can_tx_data = 1'b0;
    settle(4);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd_reg(ADDR_DIR, rv);    chk("R1 dir after reset", rv, 8'h00);
    chk("R1 oe after reset", pad_oe, 8'h00);
    wr_reg(ADDR_DIR, 8'hFF);
    rd_reg(ADDR_OUTVAL, rv); chk("R1 outval after reset", rv, 8'h00);
    wr_reg(ADDR_DIR, 8'h00);

    // Vector table: R2 R3 R4 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      wr_reg(ADDR_OUTVAL, VECS[k].outval);
      wr_reg(ADDR_DIR, VECS[k].dir);
      @(negedge clk);
      can_en = VECS[k].can_en; can_tx_data = VECS[k].can_tx;
      tmr_oc_en = VECS[k].oc_en; tmr_oc_val = VECS[k].oc_val;
      pad_in = VECS[k].pad;
      settle(3);
      @(negedge clk); #1;
      chk("R2/R4/R6 pad_out", pad_out, VECS[k].e_out);
      chk("R2/R4/R6 pad_oe", pad_oe, VECS[k].e_oe);
      rd_reg(ADDR_OUTVAL, rv); chk("R3 outval read", rv, VECS[k].e_rd0);
      rd_reg(ADDR_PADS, rv);   chk("R7 pad read", rv, VECS[k].e_rd2);
    end

    // R5: CAN receive path
    @(negedge clk);
    can_en = 1'b1; tmr_oc_en = 8'h01; tmr_oc_val = 8'h01; pad_in = 8'h00;
    settle(3); @(negedge clk); #1;
    chk("R5 rx oe low", {7'd0, pad_oe[0]}, 8'h00);
    chk("R5 rx pad_out low", {7'd0, pad_out[0]}, 8'h00);
    chk("R5 rx follows pad 0", {7'd0, can_rx_data}, 8'h00);
    @(negedge clk); pad_in = 8'h01;
    settle(3); @(negedge clk); #1;
    chk("R5 rx follows pad 1", {7'd0, can_rx_data}, 8'h01);
    @(negedge clk); can_en = 1'b0; pad_in = 8'h00;
    settle(3); @(negedge clk); #1;
    chk("R5 rx idle when disabled", {7'd0, can_rx_data}, 8'h01);
    tmr_oc_en = 8'h00;

    // R8: writes to the pad-level address are ignored
    wr_reg(ADDR_OUTVAL, 8'h3C);
    wr_reg(ADDR_DIR, 8'hFF);
    wr_reg(ADDR_PADS, 8'hFF);
    rd_reg(ADDR_OUTVAL, rv); chk("R8 outval kept", rv, 8'h3C);
    rd_reg(ADDR_DIR, rv);    chk("R8 dir kept", rv, 8'hFF);
    rd_reg(ADDR_PADS, rv);   chk("R8 pad read kept", rv, 8'h00);
    chk("R8 pad_out kept", pad_out, 8'h3C);

    // R10: capture on an output pin warns
    wr_reg(ADDR_DIR, 8'h04);
    @(negedge clk); tmr_ic_en = 8'h06; #1;
    chk("R10 warn", cfg_warn, 8'h04);
    tmr_ic_en = 8'h00;

    // R7/R11: two-edge latency
    @(negedge clk); pad_in = 8'h6B;
    @(negedge clk); #1;
    chk("R11 capture after one edge", tmr_cap_in, 8'h00);
    @(negedge clk); #1;
    chk("R11 capture after two edges", tmr_cap_in, 8'h6B);
    bus_addr = ADDR_PADS; #1;
    chk("R7 pad read after two edges", bus_rdata, 8'h6B);

    // R9: synchronizer runs during reset
    @(negedge clk); rst_n = 1'b0; pad_in = 8'h96;
    settle(3);
    rd_reg(ADDR_PADS, rv); chk("R9 pad read in reset", rv, 8'h96);
    chk("R1 oe in reset", pad_oe, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule